// File: doc/BRIEF.md
# Panel Command Bus Engine

This block lets a host processor talk to up to two small display panels over a parallel, strobe-driven command bus. The host stages a word in a write-data register, where two flag bits say that the word is meant to be written and whether it is an index (command) or a data word. A separate start register then launches the transfer and names the target panel. A read works the same way. The host first arms the read-data register, then launches through a read-start register. The returned 16-bit value appears in the low half of the read-data register.

A single sequencer owns the panel bus. Each transfer has three phases. In the setup phase, chip-select and the register-select line are driven. Next comes a write or read strobe lasting `STROBE_CYC` clocks. A hold phase follows, in which the strobe is released while chip-select is still asserted. A status busy flag covers the whole transfer, and software polls it before issuing the next start. A start that collides with a running transfer, or that is not properly prepared, is dropped and raises a sticky error flag.

Top module: `panel_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, both chip-selects, the write strobe and the read strobe are high, the output enable is low, and the status and write-data registers read 0.
- R2: Writing 1 to bit 0 of the write-start register (address 2) launches a write when the write-data register (address 0) has bit 28 set. The bus shows one setup cycle, then a write strobe low for exactly `STROBE_CYC` cycles, then one hold cycle. The write-data register's low 16 bits are driven on the data bus throughout.
- R3: Bit 24 of the write-data register selects the cycle kind. When it is 0, register-select is low (index cycle). When it is 1, register-select is high (data cycle). The value holds for the whole transfer.
- R4: Bit 1 of either start register picks the panel. A 0 asserts chip-select 0 (main panel) and a 1 asserts chip-select 1 (secondary panel). The other select stays high, and at most one select is ever low.
- R5: Status bit 1 (busy) at address 4 becomes 1 at the clock edge that accepts a start. It stays 1 for `STROBE_CYC`+2 cycles and returns to 0 when the hold cycle ends.
- R6: A start written while busy is ignored, and the transfer in progress is unaffected. Such a start sets status bit 4 (error), which stays set until the status register is written with bit 4 set.
- R7: A write start while bit 28 of the write-data register is 0 causes no bus activity and sets the error bit. A read start that is not armed does the same. A start-register write with bit 0 clear has no effect.
- R8: Writing the read-data register (address 1) with bit 24 set arms one read. Writing 1 to bit 0 of the read-start register (address 3) launches it. Register-select is high, the read strobe is low for `STROBE_CYC` cycles, and the write strobe stays high. Each launch consumes the arm.
- R9: The panel input is captured at the clock edge where the read strobe rises. Address 1 then returns the captured value in bits 15:0, with zero above.
- R10: The data-bus output enable is high from setup through hold of a write only, and never during a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address (0 wdata, 1 rdata, 2 wstart, 3 rstart, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pnl_cs_n | output | 2 | Active-low chip-selects, bit 0 main panel, bit 1 secondary |
| pnl_rs | output | 1 | Register-select: 0 index, 1 data |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_dout | output | DW | Data bus output value |
| pnl_doe | output | 1 | Data bus output enable |
| pnl_din | input | DW | Data bus input value |

## Verification
The write path is swept over both panels, both cycle kinds and data words with all-zero, all-one, alternating and panel-dependent bit patterns. Each bus signal is checked cycle by cycle against a phase count, which separates the select, register-select, strobe-length and output-enable behaviour. Reads are swept over both panels with several input patterns, which shows the capture edge and the zero upper half. Collision starts, unprepared starts, start writes with bit 0 clear and a second read without re-arming each show that a dropped start leaves the bus idle. They also show which of these cases raise the sticky error flag.

// File: rtl/pce_pkg.sv
// Package: shared state encoding, register addresses and bit positions
// of the panel command engine. Assumes a 32-bit host register interface.
package pce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } pce_state_t;

    localparam logic [2:0] A_WDATA  = 3'd0;
    localparam logic [2:0] A_RDATA  = 3'd1;
    localparam logic [2:0] A_WSTART = 3'd2;
    localparam logic [2:0] A_RSTART = 3'd3;
    localparam logic [2:0] A_STATUS = 3'd4;

    localparam int B_WRITE_FLAG = 28;
    localparam int B_DATA_FLAG  = 24;
    localparam int B_GO         = 0;
    localparam int B_SEL        = 1;
    localparam int B_BUSY       = 1;
    localparam int B_ERR        = 4;
endpackage

// File: rtl/pce_regs.sv
// Host register file of the panel command engine.
// Holds the staged write word, the read arm, the captured read value
// and the sticky error flag. Decodes start writes into a one-cycle
// launch request for the sequencer.
// Assumes DW <= 24, so data never overlaps the flag bits.
module pce_regs
    import pce_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          busy_i,
    input  logic          cap_vld_i,
    input  logic [DW-1:0] cap_dat_i,
    output logic          launch_o,
    output logic          launch_rd_o,
    output logic          launch_sel_o,
    output logic          launch_rs_o,
    output logic [DW-1:0] launch_dat_o
);
    localparam int PAD = 32 - DW;

    logic [31:0]   wdat_q;
    logic          armed_q;
    logic [DW-1:0] cap_q;
    logic          err_q;

    logic wstart_hit, rstart_hit, w_ok, r_ok;

    // Decode start writes and decide whether each is accepted.
    always_comb begin
        wstart_hit = reg_we && (reg_addr == A_WSTART) && reg_wdata[B_GO];
        rstart_hit = reg_we && (reg_addr == A_RSTART) && reg_wdata[B_GO];
        w_ok       = wstart_hit && !busy_i && wdat_q[B_WRITE_FLAG];
        r_ok       = rstart_hit && !busy_i && armed_q;
    end

    assign launch_o     = w_ok || r_ok;
    assign launch_rd_o  = r_ok;
    assign launch_sel_o = reg_wdata[B_SEL];
    assign launch_rs_o  = r_ok ? 1'b1 : wdat_q[B_DATA_FLAG];
    assign launch_dat_o = wdat_q[DW-1:0];

    // Staged write word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdat_q <= '0;
        else if (reg_we && reg_addr == A_WDATA)
            wdat_q <= reg_wdata;
    end

    // Read arm: set by the setup write, consumed by an accepted read start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (r_ok)
            armed_q <= 1'b0;
        else if (reg_we && reg_addr == A_RDATA)
            armed_q <= reg_wdata[B_DATA_FLAG];
    end

    // Captured panel read value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (cap_vld_i)
            cap_q <= cap_dat_i;
    end

    // Sticky error: set by a rejected start, cleared by writing 1 to it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if ((wstart_hit && !w_ok) || (rstart_hit && !r_ok))
            err_q <= 1'b1;
        else if (reg_we && reg_addr == A_STATUS && reg_wdata[B_ERR])
            err_q <= 1'b0;
    end

    // Host read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_WDATA:  reg_rdata = wdat_q;
            A_RDATA:  reg_rdata = {{PAD{1'b0}}, cap_q};
            A_STATUS: begin
                reg_rdata[B_BUSY] = busy_i;
                reg_rdata[B_ERR]  = err_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    p_busy_after_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> busy_i);

    p_err_on_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wstart_hit && busy_i) |=> err_q);

    p_no_launch_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !launch_o);
endmodule

// File: rtl/pce_seq.sv
// Bus sequencer of the panel command engine.
// Runs one transfer per launch: setup (select and register-select
// driven), strobe low for STROBE_CYC clocks, hold (strobe released,
// select kept). Captures panel input as the read strobe rises.
// Assumes launch is only raised while idle.
module pce_seq
    import pce_pkg::*;
#(
    parameter int DW         = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          launch_rd_i,
    input  logic          launch_sel_i,
    input  logic          launch_rs_i,
    input  logic [DW-1:0] launch_dat_i,
    output logic          busy_o,
    output logic          cap_vld_o,
    output logic [DW-1:0] cap_dat_o,
    output logic [1:0]    pnl_cs_n,
    output logic          pnl_rs,
    output logic          pnl_wr_n,
    output logic          pnl_rd_n,
    output logic [DW-1:0] pnl_dout,
    output logic          pnl_doe,
    input  logic [DW-1:0] pnl_din
);
    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

    pce_state_t    st_q;
    logic [CNT_W-1:0] cnt_q;
    logic          rd_q, sel_q, rs_q;
    logic [DW-1:0] dat_q;
    logic          strobe_end;

    assign strobe_end = (st_q == ST_STROBE) && (cnt_q == LAST);

    // Phase sequencing and strobe width counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE:   if (launch_i) st_q <= ST_SETUP;
                ST_SETUP:  begin st_q <= ST_STROBE; cnt_q <= '0; end
                ST_STROBE: begin
                    if (strobe_end) st_q <= ST_HOLD;
                    else            cnt_q <= cnt_q + 1'b1;
                end
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // Transfer attributes latched at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            sel_q <= 1'b0;
            rs_q  <= 1'b0;
            dat_q <= '0;
        end else if (st_q == ST_IDLE && launch_i) begin
            rd_q  <= launch_rd_i;
            sel_q <= launch_sel_i;
            rs_q  <= launch_rs_i;
            dat_q <= launch_dat_i;
        end
    end

    // Decode bus pins from the registered phase.
    always_comb begin
        busy_o    = (st_q != ST_IDLE);
        pnl_cs_n  = busy_o ? (sel_q ? 2'b01 : 2'b10) : 2'b11;
        pnl_rs    = rs_q;
        pnl_wr_n  = !((st_q == ST_STROBE) && !rd_q);
        pnl_rd_n  = !((st_q == ST_STROBE) && rd_q);
        pnl_doe   = busy_o && !rd_q;
        pnl_dout  = dat_q;
        cap_vld_o = strobe_end && rd_q;
        cap_dat_o = pnl_din;
    end

    p_cs_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pnl_cs_n));

    p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pnl_wr_n && !pnl_rd_n));

    p_doe_not_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pnl_rd_n |-> !pnl_doe);

    p_rs_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(pnl_rs));

    p_strobe_ends_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |-> (pnl_wr_n && pnl_rd_n && pnl_cs_n != 2'b11));
endmodule

// File: rtl/panel_cmd_engine.sv
// Top of the panel command engine: register file plus bus sequencer.
// Assumes a single clock domain shared with the host and the panel bus.
module panel_cmd_engine
    import pce_pkg::*;
#(
    parameter int DW         = 16,
    parameter int STROBE_CYC = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [1:0]    pnl_cs_n,
    output logic          pnl_rs,
    output logic          pnl_wr_n,
    output logic          pnl_rd_n,
    output logic [DW-1:0] pnl_dout,
    output logic          pnl_doe,
    input  logic [DW-1:0] pnl_din
);
    logic          busy, cap_vld, launch, launch_rd, launch_sel, launch_rs;
    logic [DW-1:0] cap_dat, launch_dat;

    pce_regs #(.DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy_i       (busy),
        .cap_vld_i    (cap_vld),
        .cap_dat_i    (cap_dat),
        .launch_o     (launch),
        .launch_rd_o  (launch_rd),
        .launch_sel_o (launch_sel),
        .launch_rs_o  (launch_rs),
        .launch_dat_o (launch_dat)
    );

    pce_seq #(.DW(DW), .STROBE_CYC(STROBE_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_i     (launch),
        .launch_rd_i  (launch_rd),
        .launch_sel_i (launch_sel),
        .launch_rs_i  (launch_rs),
        .launch_dat_i (launch_dat),
        .busy_o       (busy),
        .cap_vld_o    (cap_vld),
        .cap_dat_o    (cap_dat),
        .pnl_cs_n     (pnl_cs_n),
        .pnl_rs       (pnl_rs),
        .pnl_wr_n     (pnl_wr_n),
        .pnl_rd_n     (pnl_rd_n),
        .pnl_dout     (pnl_dout),
        .pnl_doe      (pnl_doe),
        .pnl_din      (pnl_din)
    );
endmodule

// File: tb/panel_cmd_engine_tb.sv
module panel_cmd_engine_tb;
    localparam int S = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd4;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    pnl_cs_n;
    logic          pnl_rs, pnl_wr_n, pnl_rd_n, pnl_doe;
    logic [DW-1:0] pnl_dout;
    logic [DW-1:0] pnl_din = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    panel_cmd_engine #(.DW(DW), .STROBE_CYC(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pnl_cs_n(pnl_cs_n),
        .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
        .pnl_dout(pnl_dout), .pnl_doe(pnl_doe), .pnl_din(pnl_din)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
    endtask

    task automatic status_now(output logic [31:0] v);
        reg_addr = 3'd4; #1; v = reg_rdata;
    endtask

    task automatic idle_window(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            #1;
            chk(tag, {pnl_cs_n, pnl_wr_n, pnl_rd_n}, 4'b1111);
            @(negedge clk);
        end
    endtask

    // R2 R3 R4 R5 R10: one write transfer checked phase by phase.
    task automatic do_write(input bit sel, input bit isdata, input logic [15:0] val);
        logic [31:0] w;
        w = 32'h1000_0000 | (isdata ? 32'h0100_0000 : 32'h0) | {16'h0, val};
        reg_write(3'd0, w);
        reg_addr = 3'd0; #1; chk("R2 wdata readback", reg_rdata, w);
        reg_addr = 3'd4;
        @(negedge clk);
        reg_write(3'd2, {30'h0, sel, 1'b1});
        for (int i = 0; i <= S + 2; i++) begin
            bit act;
            act = (i <= S + 1);
            #1;
            chk("R4 select", {30'h0, pnl_cs_n}, act ? (sel ? 32'h1 : 32'h2) : 32'h3);
            chk("R2 write strobe", {31'h0, pnl_wr_n}, (i >= 1 && i <= S) ? 32'h0 : 32'h1);
            chk("R8 read strobe idle", {31'h0, pnl_rd_n}, 32'h1);
            chk("R10 output enable", {31'h0, pnl_doe}, {31'h0, act});
            chk("R5 busy", {31'h0, reg_rdata[1]}, {31'h0, act});
            if (act) begin
                chk("R3 register select", {31'h0, pnl_rs}, {31'h0, isdata});
                chk("R2 data bus", {16'h0, pnl_dout}, {16'h0, val});
            end
            @(negedge clk);
        end
    endtask

    // R8 R9: one read transfer.
    task automatic do_read(input bit sel, input logic [15:0] din);
        pnl_din = ~din;
        reg_write(3'd1, 32'h0100_0000);
        reg_write(3'd3, {30'h0, sel, 1'b1});
        for (int i = 0; i <= S + 2; i++) begin
            bit act;
            act = (i <= S + 1);
            if (i == S) pnl_din = din;
            #1;
            chk("R4 read select", {30'h0, pnl_cs_n}, act ? (sel ? 32'h1 : 32'h2) : 32'h3);
            chk("R8 read strobe", {31'h0, pnl_rd_n}, (i >= 1 && i <= S) ? 32'h0 : 32'h1);
            chk("R8 write strobe idle", {31'h0, pnl_wr_n}, 32'h1);
            chk("R10 no enable on read", {31'h0, pnl_doe}, 32'h0);
            chk("R5 busy on read", {31'h0, reg_rdata[1]}, {31'h0, act});
            if (act) chk("R8 register select high", {31'h0, pnl_rs}, 32'h1);
            if (i == S + 1) pnl_din = ~din;
            @(negedge clk);
        end
        reg_addr = 3'd1; #1;
        chk("R9 captured value", reg_rdata, {16'h0, din});
        reg_addr = 3'd4;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        logic [15:0] pats [4];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA55A; pats[3] = 16'h0001;

        repeat (3) @(negedge clk);
        #1;
        chk("R1 selects", {30'h0, pnl_cs_n}, 32'h3);
        chk("R1 strobes", {30'h0, pnl_wr_n, pnl_rd_n}, 32'h3);
        chk("R1 enable", {31'h0, pnl_doe}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        status_now(st); chk("R1 status", st, 32'h0);
        reg_addr = 3'd0; #1; chk("R1 wdata", reg_rdata, 32'h0);
        reg_addr = 3'd4;
        @(negedge clk);

        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 2; k++)
                for (int p = 0; p < 4; p++)
                    do_write(s[0], k[0], pats[p] ^ (s[0] ? 16'h3C00 : 16'h0000));

        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++)
                do_read(s[0], pats[p] ^ 16'h1234 ^ {15'h0, s[0]});

        // R6: collision start while busy.
        reg_write(3'd0, 32'h1000_00AB);
        @(negedge clk);
        reg_write(3'd2, 32'h1);
        reg_write(3'd2, 32'h3);
        for (int i = 1; i <= S + 2; i++) begin
            #1;
            chk("R6 running transfer kept", {30'h0, pnl_cs_n}, (i <= S + 1) ? 32'h2 : 32'h3);
            @(negedge clk);
        end
        status_now(st); chk("R6 error set", st, 32'h10);
        idle_window("R6 no second cycle", 4);
        reg_write(3'd4, 32'h10);
        status_now(st); chk("R6 error cleared", st, 32'h0);

        // R7: start with write flag clear.
        reg_write(3'd0, 32'h0100_5555);
        reg_write(3'd2, 32'h1);
        #1; chk("R7 unflagged write idle", {30'h0, pnl_cs_n}, 32'h3);
        idle_window("R7 unflagged write idle", 3);
        status_now(st); chk("R7 error on unflagged", st, 32'h10);
        reg_write(3'd4, 32'h10);

        // R7: start register write with go bit clear has no effect.
        reg_write(3'd0, 32'h1000_1111);
        reg_write(3'd2, 32'h2);
        idle_window("R7 go clear idle", 3);
        status_now(st); chk("R7 go clear no error", st, 32'h0);

        // R7 R8: unarmed read, then a second read after one consumed arm.
        reg_write(3'd3, 32'h1);
        idle_window("R7 unarmed read idle", 3);
        status_now(st); chk("R7 error on unarmed read", st, 32'h10);
        reg_write(3'd4, 32'h10);
        do_read(1'b0, 16'hBEEF);
        reg_write(3'd3, 32'h1);
        idle_window("R8 arm consumed", 3);
        status_now(st); chk("R8 second read rejected", st, 32'h10);
        reg_addr = 3'd1; #1; chk("R9 value kept", reg_rdata, 32'h0000_BEEF);
        reg_addr = 3'd4;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule